// File: doc/BRIEF.md
# Dual-Execution Result Checker with Majority Vote

This block sits at the write-back boundary of a four-slot, statically scheduled wide-issue data path. In that data path the compiler places every operation twice, on two different execution units. The first copy, called the original, parks its result in a small scratch file of eight entries. The second copy, called the duplicate, arrives later in the schedule. It names the same scratch entry and the unit that ran the original. The block compares the two results and commits the duplicate's result on the duplicate's slot only when they agree. An original result never reaches write-back by itself, so a disagreement can always be undone.

When the two results disagree and neither unit is already under suspicion, the block enters recovery. Recovery stalls the front end and rebinds the operation to a third unit. The third result settles the question by majority: the unit that lost the vote is marked faulty, and the winning value is committed. Fault marks are sticky until reset. A unit that carries a mark is bypassed from then on without a new vote: its partner's value is committed directly. A marked unit whose result later agrees with its partner's has its earlier detection reported as transient.

The block is a two-state machine. In `ST_RUN` it accepts one bundle per cycle. In `ST_REEXEC` it settles one disputed slot per cycle, lowest slot first, while the front end waits. It moves between the states on four transitions:
- `T_HOLD`: RUN to RUN, taken when no slot disagrees.
- `T_MISMATCH`: RUN to REEXEC, taken when at least one slot needs a vote.
- `T_NEXT`: REEXEC to REEXEC, taken when more disputed slots remain.
- `T_DONE`: REEXEC to RUN, taken once the last disputed slot has been settled.

Top module: `dual_exec_voter`

## Requirements
- R1: After reset, `commit_valid`, `unit_faulty` and `unit_transient` are all zero and `recovery_mode` is low.
- R2: An operation with `op_is_dup`=0 stores its `eu_result` in scratch entry `op_tmp_idx` and never produces a commit.
- R3: When a duplicate on slot d finds a live entry, its result equals the stored one, and neither unit d nor unit `op_mate` is marked, then one cycle later `commit_valid[d]` equals `wb_enable[d]` and commit data slice d carries the result. Slot d occupies bits d*16 to d*16+15.
- R4: A duplicate's comparison frees its scratch entry. A duplicate that names an entry that is empty produces no commit and no recovery.
- R5: A disagreement between unmarked units raises `recovery_mode` from the next cycle. Recovery takes one cycle per disputed slot, and disputed slots are handled in ascending slot order; `rebind_slot` names the slot being settled.
- R6: During recovery, `rebind_unit` is the lowest-numbered unit that is neither the slot's own unit nor its partner and carries no fault mark. If no such unit exists, it is the lowest unit other than those two.
- R7: If `rebind_result` equals the original's result, the duplicate's unit is marked faulty and the original's result is committed. Otherwise the partner unit is marked faulty and `rebind_result` is committed. Both the commit and the mark appear in the cycle after the rebind cycle.
- R8: If exactly one of the two units is marked, the other unit's value is committed without recovery. If both are marked, the duplicate's value is committed without recovery.
- R9: When a marked unit's result equals its unmarked partner's, that unit's bit in `unit_transient` is set one cycle later, and its `unit_faulty` bit stays set.
- R10: `unit_faulty` and `unit_transient` bits, once set, stay set until reset.
- R11: Operation inputs presented while `recovery_mode` is high are ignored: they write no scratch entry and commit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | SLOTS | Slot carries an operation this cycle |
| op_is_dup | input | SLOTS | 0 = original copy, 1 = duplicate copy |
| op_tmp_idx | input | SLOTS*IW | Scratch entry index per slot |
| op_mate | input | SLOTS*UW | Unit running the counterpart copy |
| eu_result | input | SLOTS*W | Execution unit result per slot |
| wb_enable | input | SLOTS | Operation writes back when committed |
| rebind_result | input | W | Result of the rebound third execution |
| commit_valid | output | SLOTS | Committed result present on slot |
| commit_data | output | SLOTS*W | Committed result per slot |
| unit_faulty | output | SLOTS | Sticky fault mark per unit |
| unit_transient | output | SLOTS | Sticky transient classification per unit |
| recovery_mode | output | 1 | Recovery active; front end must stall |
| rebind_slot | output | UW | Slot currently being settled |
| rebind_unit | output | UW | Unit chosen to re-execute it |

## Verification
Clean bundles with random values, random partner rotations and random write-back masks show that agreement commits the duplicate's value on the right slot and that nothing is committed before the duplicate arrives. A single corrupted duplicate result drives the vote path and checks that the unit that lost the vote is blamed. A later clean bundle through the same unit then checks masking and the transient classification. Two units faulty at once produce two disputes in one bundle, which separates ascending settle order, third-unit selection that skips a freshly marked unit, and the dropping of inputs during the stall. Lone duplicates naming freed or never-written entries tell a live entry from an empty one.

// File: rtl/dxc_pkg.sv
package dxc_pkg;

    // Checker sequencing: accept bundles, or settle disputed slots by vote.
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REEXEC = 1'b1
    } dxc_state_e;

endpackage

// File: rtl/dxc_tmp_file.sv
// Scratch store holding original results until their duplicates compare.
module dxc_tmp_file #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    parameter int SLOTS = 4,
    parameter int IW    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [SLOTS-1:0]   wr_en,
    input  logic [SLOTS*IW-1:0] wr_idx,
    input  logic [SLOTS*W-1:0] wr_data,
    input  logic [SLOTS*IW-1:0] rd_idx,
    input  logic [SLOTS-1:0]   rd_free,
    output logic [SLOTS-1:0]   rd_hit,
    output logic [SLOTS*W-1:0] rd_data
);

    logic [DEPTH-1:0] live_q;
    logic [W-1:0]     cell_q [DEPTH];

    // Frees first, then writes: a write in the same cycle wins.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
        end else if (en) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (rd_free[s]) live_q[rd_idx[s*IW +: IW]] <= 1'b0;
            end
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_en[s]) live_q[wr_idx[s*IW +: IW]] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_en[s]) cell_q[wr_idx[s*IW +: IW]] <= wr_data[s*W +: W];
            end
        end
    end

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            rd_hit[s]          = live_q[rd_idx[s*IW +: IW]];
            rd_data[s*W +: W]  = cell_q[rd_idx[s*IW +: IW]];
        end
    end

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_chk
            // R2: a stored original makes its entry live
            a_r2_entry_live: assert property (@(posedge clk) disable iff (!rst_n)
                (en && wr_en[g]) |=> live_q[$past(wr_idx[g*IW +: IW])])
                else $error("R2 entry not live after write");
            // R4: a completed comparison releases the entry
            a_r4_entry_freed: assert property (@(posedge clk) disable iff (!rst_n)
                (en && rd_free[g] && (wr_en == '0)) |=> !live_q[$past(rd_idx[g*IW +: IW])])
                else $error("R4 entry still live after compare");
        end
    endgenerate

endmodule

// File: rtl/dxc_slot_cmp.sv
// Per-slot decision for a duplicate: commit, mask, or request a vote.
module dxc_slot_cmp #(
    parameter int W     = 16,
    parameter int SLOTS = 4,
    parameter int UW    = 2,
    parameter int SLOT  = 0
) (
    input  logic             dup_go,
    input  logic             ent_hit,
    input  logic [UW-1:0]    partner,
    input  logic [W-1:0]     orig_res,
    input  logic [W-1:0]     dup_res,
    input  logic [SLOTS-1:0] bad_units,
    output logic             take,
    output logic             keep,
    output logic [W-1:0]     keep_data,
    output logic             need_vote,
    output logic [SLOTS-1:0] trans_mark
);

    logic own_bad;
    logic mate_bad;
    logic same;

    always_comb begin
        take       = dup_go && ent_hit && (partner != UW'(SLOT));
        own_bad    = bad_units[SLOT];
        mate_bad   = bad_units[partner];
        same       = (orig_res == dup_res);
        keep       = 1'b0;
        keep_data  = dup_res;
        need_vote  = 1'b0;
        trans_mark = '0;
        if (take) begin
            if (own_bad && !mate_bad) begin
                keep             = 1'b1;
                keep_data        = orig_res;
                trans_mark[SLOT] = same;
            end else if (mate_bad && !own_bad) begin
                keep                = 1'b1;
                trans_mark[partner] = same;
            end else if (own_bad) begin
                keep = 1'b1;
            end else if (same) begin
                keep = 1'b1;
            end else begin
                need_vote = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dxc_vote.sv
// Third-unit selection and two-of-three decision for one disputed slot.
module dxc_vote #(
    parameter int W     = 16,
    parameter int SLOTS = 4,
    parameter int UW    = 2
) (
    input  logic [UW-1:0]    cur_slot,
    input  logic [UW-1:0]    mate,
    input  logic [W-1:0]     orig_res,
    input  logic [W-1:0]     third_res,
    input  logic [SLOTS-1:0] bad_units,
    output logic [UW-1:0]    third_unit,
    output logic [UW-1:0]    blamed,
    output logic [W-1:0]     vote_data
);

    logic got;

    always_comb begin
        third_unit = '0;
        got        = 1'b0;
        for (int u = 0; u < SLOTS; u++) begin
            if (!got && UW'(u) != cur_slot && UW'(u) != mate && !bad_units[u]) begin
                third_unit = UW'(u);
                got        = 1'b1;
            end
        end
        for (int u = 0; u < SLOTS; u++) begin
            if (!got && UW'(u) != cur_slot && UW'(u) != mate) begin
                third_unit = UW'(u);
                got        = 1'b1;
            end
        end
        if (third_res == orig_res) begin
            blamed    = cur_slot;
            vote_data = orig_res;
        end else begin
            blamed    = mate;
            vote_data = third_res;
        end
    end

endmodule

// File: rtl/dual_exec_voter.sv
module dual_exec_voter
    import dxc_pkg::*;
#(
    parameter int W         = 16,
    parameter int SLOTS     = 4,
    parameter int TMP_DEPTH = 8,
    localparam int UW = $clog2(SLOTS),
    localparam int IW = $clog2(TMP_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOTS-1:0]   op_valid,
    input  logic [SLOTS-1:0]   op_is_dup,
    input  logic [SLOTS*IW-1:0] op_tmp_idx,
    input  logic [SLOTS*UW-1:0] op_mate,
    input  logic [SLOTS*W-1:0] eu_result,
    input  logic [SLOTS-1:0]   wb_enable,
    input  logic [W-1:0]       rebind_result,
    output logic [SLOTS-1:0]   commit_valid,
    output logic [SLOTS*W-1:0] commit_data,
    output logic [SLOTS-1:0]   unit_faulty,
    output logic [SLOTS-1:0]   unit_transient,
    output logic               recovery_mode,
    output logic [UW-1:0]      rebind_slot,
    output logic [UW-1:0]      rebind_unit
);

    dxc_state_e state_q, state_d;
    logic running;

    logic [SLOTS-1:0]   dup_go;
    logic [SLOTS-1:0]   tmp_hit;
    logic [SLOTS*W-1:0] tmp_data;
    logic [SLOTS-1:0]   take;
    logic [SLOTS-1:0]   keep;
    logic [SLOTS*W-1:0] keep_data;
    logic [SLOTS-1:0]   need;
    logic [SLOTS-1:0]   trans_mark [SLOTS];
    logic [SLOTS-1:0]   trans_any;

    logic [SLOTS-1:0]   pend_q;
    logic [W-1:0]       sv_orig [SLOTS];
    logic [UW-1:0]      sv_mate [SLOTS];
    logic [SLOTS-1:0]   sv_wb;
    logic [UW-1:0]      cur_slot;
    logic [SLOTS-1:0]   cur_hot;

    logic [UW-1:0]      third_unit;
    logic [UW-1:0]      blamed;
    logic [W-1:0]       vote_data;

    logic [SLOTS-1:0]   cv_q;
    logic [SLOTS*W-1:0] cd_q;
    logic [SLOTS-1:0]   fault_q;
    logic [SLOTS-1:0]   trans_q;

    assign running = (state_q == ST_RUN);
    assign dup_go  = op_valid & op_is_dup & {SLOTS{running}};

    dxc_tmp_file #(.W(W), .DEPTH(TMP_DEPTH), .SLOTS(SLOTS), .IW(IW)) u_tmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (running),
        .wr_en   (op_valid & ~op_is_dup),
        .wr_idx  (op_tmp_idx),
        .wr_data (eu_result),
        .rd_idx  (op_tmp_idx),
        .rd_free (take),
        .rd_hit  (tmp_hit),
        .rd_data (tmp_data)
    );

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            dxc_slot_cmp #(.W(W), .SLOTS(SLOTS), .UW(UW), .SLOT(g)) u_cmp (
                .dup_go     (dup_go[g]),
                .ent_hit    (tmp_hit[g]),
                .partner    (op_mate[g*UW +: UW]),
                .orig_res   (tmp_data[g*W +: W]),
                .dup_res    (eu_result[g*W +: W]),
                .bad_units  (fault_q),
                .take       (take[g]),
                .keep       (keep[g]),
                .keep_data  (keep_data[g*W +: W]),
                .need_vote  (need[g]),
                .trans_mark (trans_mark[g])
            );
        end
    endgenerate

    always_comb begin
        trans_any = '0;
        for (int s = 0; s < SLOTS; s++) trans_any = trans_any | trans_mark[s];
    end

    // Lowest pending slot is settled first.
    always_comb begin
        cur_slot = '0;
        cur_hot  = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (pend_q[s]) begin
                cur_slot = UW'(s);
                cur_hot  = '0;
                cur_hot[s] = 1'b1;
            end
        end
    end

    dxc_vote #(.W(W), .SLOTS(SLOTS), .UW(UW)) u_vote (
        .cur_slot   (cur_slot),
        .mate       (sv_mate[cur_slot]),
        .orig_res   (sv_orig[cur_slot]),
        .third_res  (rebind_result),
        .bad_units  (fault_q),
        .third_unit (third_unit),
        .blamed     (blamed),
        .vote_data  (vote_data)
    );

    // Transitions: T_HOLD, T_MISMATCH, T_NEXT, T_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (|need) state_d = ST_REEXEC;
            ST_REEXEC: if ((pend_q & ~cur_hot) == '0) state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (running) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (need[s]) begin
                    sv_orig[s] <= tmp_data[s*W +: W];
                    sv_mate[s] <= op_mate[s*UW +: UW];
                    sv_wb[s]   <= wb_enable[s];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cv_q    <= '0;
            cd_q    <= '0;
            fault_q <= '0;
            trans_q <= '0;
            pend_q  <= '0;
        end else begin
            cv_q <= '0;
            unique case (state_q)
                ST_RUN: begin
                    for (int s = 0; s < SLOTS; s++) begin
                        if (keep[s] && wb_enable[s]) begin
                            cv_q[s]          <= 1'b1;
                            cd_q[s*W +: W]   <= keep_data[s*W +: W];
                        end
                    end
                    pend_q  <= need;
                    trans_q <= trans_q | trans_any;
                end
                ST_REEXEC: begin
                    if (sv_wb[cur_slot]) begin
                        cv_q[cur_slot]          <= 1'b1;
                        cd_q[cur_slot*W +: W]   <= vote_data;
                    end
                    fault_q[blamed] <= 1'b1;
                    pend_q          <= pend_q & ~cur_hot;
                end
            endcase
        end
    end

    assign commit_valid   = cv_q;
    assign commit_data    = cd_q;
    assign unit_faulty    = fault_q;
    assign unit_transient = trans_q;
    assign recovery_mode  = (state_q == ST_REEXEC);
    assign rebind_slot    = cur_slot;
    assign rebind_unit    = third_unit;

    // R5: a dispute between unmarked units starts recovery next cycle
    a_r5_enter_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (|need)) |=> recovery_mode)
        else $error("R5 recovery not entered");

    // R5: every recovery cycle retires one disputed slot
    a_r5_drain: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_mode |=> ($countones(pend_q) < $past($countones(pend_q))))
        else $error("R5 pending set did not shrink");

    // R6: the rebound unit is neither of the disputing units
    a_r6_third_distinct: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_mode |-> ((rebind_unit != rebind_slot) && (rebind_unit != sv_mate[cur_slot])))
        else $error("R6 third unit collides");

    // R7: the vote loser is marked in the following cycle
    a_r7_blame_marked: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_mode |=> unit_faulty[$past(blamed)])
        else $error("R7 loser not marked");

    // R11: at most one commit follows a recovery cycle
    a_r11_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        recovery_mode |=> ($countones(commit_valid) <= 1))
        else $error("R11 extra commit during recovery");

    // R10: marks never clear outside reset
    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unit_faulty & $past(unit_faulty)) == $past(unit_faulty)))
        else $error("R10 fault mark cleared");
    a_r10_trans_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((unit_transient & $past(unit_transient)) == $past(unit_transient)))
        else $error("R10 transient mark cleared");

endmodule

// File: tb/dual_exec_voter_tb.sv
`timescale 1ns/1ps
module dual_exec_voter_tb;

    localparam int W  = 16;
    localparam int S  = 4;
    localparam int IW = 3;
    localparam int UW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [S-1:0]    op_valid, op_is_dup, wb_enable;
    logic [S*IW-1:0] op_tmp_idx;
    logic [S*UW-1:0] op_mate;
    logic [S*W-1:0]  eu_result;
    logic [W-1:0]    rebind_result;
    logic [S-1:0]    commit_valid, unit_faulty, unit_transient;
    logic [S*W-1:0]  commit_data;
    logic            recovery_mode;
    logic [UW-1:0]   rebind_slot, rebind_unit;

    dual_exec_voter #(.W(W), .SLOTS(S), .TMP_DEPTH(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_dup(op_is_dup),
        .op_tmp_idx(op_tmp_idx), .op_mate(op_mate), .eu_result(eu_result),
        .wb_enable(wb_enable), .rebind_result(rebind_result),
        .commit_valid(commit_valid), .commit_data(commit_data),
        .unit_faulty(unit_faulty), .unit_transient(unit_transient),
        .recovery_mode(recovery_mode), .rebind_slot(rebind_slot), .rebind_unit(rebind_unit)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [3:0] ef, et, perm, shot;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] corr(int u, logic [3:0] m);
        return m[u] ? W'(16'h0101 << u) : '0;
    endfunction

    function automatic int third_fn(int c, int m, logic [3:0] f);
        for (int u = 0; u < S; u++) if (u != c && u != m && !f[u]) return u;
        for (int u = 0; u < S; u++) if (u != c && u != m) return u;
        return 0;
    endfunction

    task automatic idle();
        op_valid = '0; op_is_dup = '0; op_tmp_idx = '0; op_mate = '0;
        eu_result = '0; wb_enable = '0; rebind_result = '0;
    endtask

    task automatic set_slot(int s, bit dup, int idx, int mate, logic [W-1:0] r, bit wb);
        op_valid[s] = 1'b1;
        op_is_dup[s] = dup;
        op_tmp_idx[s*IW +: IW] = IW'(idx);
        op_mate[s*UW +: UW] = UW'(mate);
        eu_result[s*W +: W] = r;
        wb_enable[s] = wb;
    endtask

    task automatic check_reset();
        chk("R1", "commit_valid", int'(commit_valid), 0);
        chk("R1", "unit_faulty", int'(unit_faulty), 0);
        chk("R1", "unit_transient", int'(unit_transient), 0);
        chk("R1", "recovery_mode", int'(recovery_mode), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        ef = '0; et = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();
    endtask

    task automatic lone_dup(int idx, string tag);
        @(negedge clk);
        idle();
        set_slot(1, 1'b1, idx, 0, 16'h1234, 1'b1);
        @(negedge clk);
        idle();
        chk(tag, "lone duplicate commit", int'(commit_valid), 0);
        chk(tag, "lone duplicate recovery", int'(recovery_mode), 0);
    endtask

    task automatic run_bundle(int k, logic [3:0] wbm);
        logic [W-1:0] val [S];
        logic [W-1:0] r1 [S];
        logic [W-1:0] r2 [S];
        logic [W-1:0] ecd [S];
        int mate [S];
        string tg [S];
        logic [3:0] pend, ecv, tn;
        for (int s = 0; s < S; s++) val[s] = W'($urandom);
        @(negedge clk);
        idle();
        for (int s = 0; s < S; s++) set_slot(s, 1'b0, s, (s + k) % S, val[s] ^ corr(s, perm), 1'b0);
        @(negedge clk);
        chk("R2", "commit after originals", int'(commit_valid), 0);
        idle();
        for (int s = 0; s < S; s++) begin
            int d;
            d = (s + k) % S;
            mate[d] = s;
            r1[d] = val[s] ^ corr(s, perm);
            r2[d] = val[s] ^ corr(d, perm | shot);
            set_slot(d, 1'b1, s, s, r2[d], wbm[d]);
        end
        pend = '0; ecv = '0; tn = '0;
        for (int d = 0; d < S; d++) begin
            bit ob, mb, same;
            ob = ef[d]; mb = ef[mate[d]]; same = (r1[d] == r2[d]);
            tg[d] = "R3";
            ecd[d] = r2[d];
            if (ob && !mb) begin
                ecv[d] = wbm[d]; ecd[d] = r1[d]; tg[d] = "R8";
                if (same) tn[d] = 1'b1;
            end else if (mb && !ob) begin
                ecv[d] = wbm[d]; tg[d] = "R8";
                if (same) tn[mate[d]] = 1'b1;
            end else if (ob) begin
                ecv[d] = wbm[d]; tg[d] = "R8";
            end else if (same) begin
                ecv[d] = wbm[d];
            end else begin
                pend[d] = 1'b1;
            end
        end
        @(negedge clk);
        idle();
        et = et | tn;
        chk("R3", "commit_valid after duplicates", int'(commit_valid), int'(ecv));
        for (int d = 0; d < S; d++)
            if (ecv[d]) chk(tg[d], "commit_data slot", int'(commit_data[d*W +: W]), int'(ecd[d]));
        chk("R9", "unit_transient", int'(unit_transient), int'(et));
        chk("R5", "recovery_mode after dispute", int'(recovery_mode), int'(pend != 0));
        while (pend != 0) begin
            int cur, m, th;
            logic [W-1:0] r3, vd;
            int blame;
            cur = 0;
            for (int s = S - 1; s >= 0; s--) if (pend[s]) cur = s;
            m = mate[cur];
            th = third_fn(cur, m, ef);
            chk("R5", "rebind_slot", int'(rebind_slot), cur);
            chk("R6", "rebind_unit", int'(rebind_unit), th);
            r3 = val[m] ^ corr(th, perm);
            rebind_result = r3;
            set_slot(0, 1'b0, 7, 1, 16'hdead, 1'b1);
            set_slot(2, 1'b1, 5, 3, 16'hbeef, 1'b1);
            if (r3 == r1[cur]) begin blame = cur; vd = r1[cur]; end
            else begin blame = m; vd = r3; end
            ef[blame] = 1'b1;
            pend[cur] = 1'b0;
            @(negedge clk);
            idle();
            chk("R7", "commit_valid after vote", int'(commit_valid), int'(wbm[cur]) << cur);
            if (wbm[cur]) chk("R7", "vote commit data", int'(commit_data[cur*W +: W]), int'(vd));
            chk("R7", "unit_faulty after vote", int'(unit_faulty), int'(ef));
            chk("R11", "recovery_mode after vote", int'(recovery_mode), int'(pend != 0));
        end
        chk("R10", "unit_faulty held", int'(unit_faulty), int'(ef));
        chk("R10", "unit_transient held", int'(unit_transient), int'(et));
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        idle();
        perm = '0; shot = '0; ef = '0; et = '0;
        do_reset();
        for (int i = 0; i < 12; i++) run_bundle(1 + int'($urandom % 3), 4'($urandom));
        run_bundle(2, 4'b0000);
        lone_dup(0, "R4");
        lone_dup(7, "R4");
        shot = 4'b0100;
        run_bundle(1, 4'hf);
        shot = '0;
        run_bundle(3, 4'hf);
        chk("R9", "unit 2 transient and still faulty", int'({unit_transient[2], unit_faulty[2]}), 3);
        perm = 4'b0001;
        run_bundle(2, 4'hf);
        run_bundle(1, 4'hf);
        perm = 4'b1010;
        do_reset();
        run_bundle(2, 4'hf);
        lone_dup(7, "R11");
        for (int i = 0; i < 40; i++) begin
            if (i % 10 == 0) begin
                perm = ($urandom % 2 == 1) ? 4'(4'b0001 << ($urandom % 4)) : 4'b0000;
                do_reset();
            end
            shot = ($urandom % 6 == 0) ? 4'(4'b0001 << ($urandom % 4)) : 4'b0000;
            run_bundle(1 + int'($urandom % 3), 4'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule